// File: doc/BRIEF.md
# Hot-Plug Detect Request Generator

This block drives the hot-plug-detect request of a display sink connector. It watches the +5 V presence line that the attached source supplies. The request is raised only after that line has stayed high without a break for a qualification interval of one second. The interval is given to the block as a clock-cycle count.

Local firmware can rewrite the display identification memory. While it does so it holds an access request high. During that time the block forces the hot-plug request low, so the source sees an unplug. When the access request drops, the block qualifies the supply again before it raises the request. The source then sees a low pulse of guaranteed minimum length and reads the new identification data.

The presence line is asynchronous and passes through a two-flop synchronizer. The access request is synchronous to the management clock. A four-state controller decides the output, and its state is brought out for debug.

Top module: `hpd_ctrl`

## Requirements
- R1: Whenever the synchronized presence input is low, `hpd_o` is low. After `pwr5v_i` falls, `hpd_o` is low no later than the third rising clock edge.
- R2: While `rst_ni` is low, `hpd_o` is 0 and `state_o` is 0 (IDLE_LOW).
- R3: With `edid_acc_i` low, `hpd_o` rises at exactly the QUAL_CYCLES+3-th rising edge after `pwr5v_i` goes high and stays high. This count is 2 edges of synchronizer, 1 edge to enter qualification, and QUAL_CYCLES edges of qualification.
- R4: A drop of `pwr5v_i` that reaches the controller during qualification restarts the interval from zero. `hpd_o` then rises QUAL_CYCLES+3 edges after `pwr5v_i` returns high, and it stays low until then.
- R5: When `edid_acc_i` is high at a rising edge, `hpd_o` is low and `state_o` is 3 (FORCED_LOW) after that edge. Both hold for as long as `edid_acc_i` stays high, whatever `pwr5v_i` does.
- R6: When `edid_acc_i` falls, the controller goes to IDLE_LOW at the next edge. With `pwr5v_i` held high, `hpd_o` rises at the QUAL_CYCLES+2-th edge after the release.
- R7: `state_o` encodes IDLE_LOW as 0, QUALIFY as 1, HIGH as 2 and FORCED_LOW as 3. `hpd_o` is high only in HIGH.
- R8: When `edid_acc_i` is released while `pwr5v_i` is low, `hpd_o` stays low and `state_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr5v_i | input | 1 | +5 V presence from the source, asynchronous |
| edid_acc_i | input | 1 | Identification-memory access request from firmware |
| hpd_o | output | 1 | Hot-plug-detect request to the connector |
| state_o | output | 2 | Controller state, for debug |

## Verification
The assertions assume that `edid_acc_i` changes only in step with the management clock. They also assume that QUAL_CYCLES is at least 2, so that the qualification counter has a terminal value below its bound. The bench changes every input one time unit after a rising edge, so the synchronizer and the controller always see settled levels. A sweep places a one-cycle supply drop at every qualification offset from which the drop can still reach the controller before the interval ends. Each measured edge count is compared with the arithmetic delay that the requirements give.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE_LOW   = 2'd0,
    ST_QUALIFY    = 2'd1,
    ST_HIGH       = 2'd2,
    ST_FORCED_LOW = 2'd3
  } hpd_state_e;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpd_qual_timer.sv
module hpd_qual_timer #(
  parameter int unsigned QUAL_CYCLES = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // R4: counter is held at zero outside qualification
  assert_cnt_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/hpd_fsm.sv
module hpd_fsm
  import hpd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_i,
  input  logic       acc_i,
  input  logic       qual_done_i,
  output logic       qual_run_o,
  output hpd_state_e state_o
);
  hpd_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (acc_i) st_d = ST_FORCED_LOW;
    else begin
      unique case (st_q)
        ST_IDLE_LOW:   if (pwr_i) st_d = ST_QUALIFY;
        ST_QUALIFY:    if (!pwr_i) st_d = ST_IDLE_LOW;
                       else if (qual_done_i) st_d = ST_HIGH;
        ST_HIGH:       if (!pwr_i) st_d = ST_IDLE_LOW;
        ST_FORCED_LOW: st_d = ST_IDLE_LOW;
        default:       st_d = ST_IDLE_LOW;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE_LOW;
    else         st_q <= st_d;
  end

  assign qual_run_o = (st_q == ST_QUALIFY);
  assign state_o    = st_q;

  assert_forced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (st_q == ST_FORCED_LOW));
  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FORCED_LOW && !acc_i) |=> (st_q == ST_IDLE_LOW));
  assert_high_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HIGH && $past(st_q) != ST_HIGH) |-> $past(st_q) == ST_QUALIFY);
endmodule

// File: rtl/hpd_ctrl.sv
module hpd_ctrl
  import hpd_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 100_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr5v_i,
  input  logic       edid_acc_i,
  output logic       hpd_o,
  output logic [1:0] state_o
);
  logic       pwr_s;
  logic       qual_run, qual_done;
  hpd_state_e st;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr5v_i), .q_o(pwr_s)
  );

  hpd_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(qual_run), .done_o(qual_done)
  );

  hpd_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_i(pwr_s), .acc_i(edid_acc_i),
    .qual_done_i(qual_done), .qual_run_o(qual_run), .state_o(st)
  );

  assign hpd_o   = (st == ST_HIGH);
  assign state_o = st;

  assert_hpd_needs_pwr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpd_o && !pwr_s) |=> !hpd_o);
  assert_hpd_rise_qual_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hpd_o) |-> $past(qual_done));
  assert_acc_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edid_acc_i |=> !hpd_o);
endmodule

// File: tb/hpd_ctrl_tb.sv
module hpd_ctrl_tb;
  localparam int unsigned N = 8;

  logic clk = 1'b0, rst_n = 1'b0, pwr = 1'b0, acc = 1'b0;
  logic hpd;
  logic [1:0] st;
  int errs = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hpd_ctrl #(.QUAL_CYCLES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr5v_i(pwr), .edid_acc_i(acc),
    .hpd_o(hpd), .state_o(st)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // edges until hpd high, bails out at lim
  task automatic rise_after(int lim, output int n);
    n = lim + 1;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (hpd) begin n = i; break; end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n;
    tick(3);
    chk(hpd == 1'b0, "R2 hpd in reset", hpd, 0);
    chk(st == 2'd0, "R2 state in reset", st, 0);
    #1 rst_n = 1'b1;
    tick(2);
    chk(hpd == 1'b0 && st == 2'd0, "R2 idle after reset", st, 0);

    // R3 and R7 state sequence
    pwr = 1'b1;
    n = N + 10;
    for (int i = 1; i <= N + 10; i++) begin
      tick();
      if (i == 3) chk(st == 2'd1, "R7 qualify code", st, 1);
      if (hpd) begin n = i; break; end
    end
    chk(n == N + 3, "R3 rise delay", n, N + 3);
    chk(st == 2'd2, "R7 high code", st, 2);

    // R1 supply drop
    pwr = 1'b0;
    tick(2);
    chk(hpd == 1'b1, "R1 sync latency", hpd, 1);
    tick();
    chk(hpd == 1'b0, "R1 hpd low after drop", hpd, 0);
    chk(st == 2'd0, "R7 idle code", st, 0);
    tick(2);

    // R4 sweep drop offset over qualification
    for (int k = 0; k <= N - 3; k++) begin
      pwr = 1'b1;
      tick(3);
      chk(st == 2'd1, "R4 in qualify", st, 1);
      tick(k);
      pwr = 1'b0;
      tick();
      pwr = 1'b1;
      rise_after(N + 10, n);
      chk(n == N + 3, "R4 restart delay", n, N + 3);
      pwr = 1'b0;
      tick(5);
    end

    // R5 forced low from HIGH, independent of supply
    pwr = 1'b1;
    rise_after(N + 10, n);
    acc = 1'b1;
    tick();
    chk(hpd == 1'b0 && st == 2'd3, "R5 forced from high", st, 3);
    pwr = 1'b0;
    tick(4);
    chk(hpd == 1'b0 && st == 2'd3, "R5 held with supply low", st, 3);
    pwr = 1'b1;
    tick(N + 6);
    chk(hpd == 1'b0 && st == 2'd3, "R5 held past interval", st, 3);

    // R6 release requalifies
    acc = 1'b0;
    tick();
    chk(st == 2'd0, "R6 idle after release", st, 0);
    n = N + 10;
    for (int i = 2; i <= N + 10; i++) begin
      tick();
      if (hpd) begin n = i; break; end
    end
    chk(n == N + 2, "R6 reassert delay", n, N + 2);

    // R5 from idle
    pwr = 1'b0;
    tick(5);
    acc = 1'b1;
    tick();
    chk(st == 2'd3, "R5 forced from idle", st, 3);

    // R8 release with supply low
    tick(3);
    acc = 1'b0;
    tick(N + 6);
    chk(hpd == 1'b0, "R8 hpd stays low", hpd, 0);
    chk(st == 2'd0, "R8 state idle", st, 0);

    // R2 asynchronous reset from HIGH
    pwr = 1'b1;
    rise_after(N + 10, n);
    rst_n = 1'b0;
    #1;
    chk(hpd == 1'b0 && st == 2'd0, "R2 async reset", st, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule